// File: doc/BRIEF.md
# Reprogrammable Byte Memory Command Interface

This block sits on the device side of a byte-wide memory whose cells can be electrically erased and rewritten. It watches the chip-enable, output-enable and write-enable strobes together with a flag that reports programming voltage. From these it decodes command writes and runs a small mode machine. Each accepted operation produces a one-cycle request pulse for a program pulse, a bulk erase or a verify read. The pulse comes with the address and data that were latched for it. A busy output covers the fixed duration of each program or erase pulse.

The output path has three modes. In normal read mode the array is read at the live address. In verify mode the array is read at the latched address. Identifier mode returns one of two fixed code bytes. Commands are accepted only while programming voltage is present. Without it the block behaves as a plain read-only memory: the strobes select read, standby or output-disable and nothing else. Programming is a two-write sequence. Because of this, a reset issued right after the set-up write is consumed as all-ones program data, which clears no bits. A second reset is needed to abort.

All strobes and buses are sampled synchronously on `clk`. A write starts on the first sampled cycle with chip enable and write enable both low, and ends on the first cycle after that in which either one is high.

Top module: `nvm_cmd_if`

## Requirements
- R1: After reset the output mode is normal read (code 0), `busy` is low and no request pulse is high.
- R2: While `hv_ok` is low, writes are ignored. Dropping `hv_ok` forces output mode 0, clears `busy` and suppresses request pulses from the next cycle on, so a program set-up pending at that moment is lost.
- R3: Data 0x40 enters program set-up. The next write yields a one-cycle `pgm_req` in the cycle after that write ends. It carries `op_addr`, the address sampled when the write began, and `op_data`, the data sampled when it ended.
- R4: `busy` is high for exactly PGM_CYCLES cycles starting with the `pgm_req` cycle, and for exactly ERASE_CYCLES cycles starting with the `erase_req` cycle.
- R5: While `busy` is high, every command except 0xFF is ignored and leaves the mode unchanged. 0xFF clears `busy` and selects mode 0.
- R6: In program set-up, 0xFF is taken as program data and produces `pgm_req` with `op_data` 0xFF, leaving the array unchanged. A second 0xFF written right after it aborts to mode 0 with `busy` low.
- R7: Two consecutive 0x20 writes produce one `erase_req`. 0x20 followed by any other code returns to mode 0 with no erase.
- R8: 0xC0 (program verify) and 0xA0 (erase verify) each give one `vfy_req` carrying the write's address in `op_addr`. They select mode 1, in which `arr_addr` shows the latched address instead of `addr`.
- R9: 0x90 selects mode 2, where `dout` is MFR_ID when `addr[0]` is 0 and DEV_ID when it is 1.
- R10: A code other than 0x20, 0x40, 0x90, 0xA0, 0xC0 or 0xFF, written from read, verify or identifier mode, leaves the mode unchanged and raises no request.
- R11: `dout_en` is high only when `ce_n` and `oe_n` are low and `we_n` is high. Otherwise the outputs are in standby or disabled.
- R12: 0xFF written from verify or identifier mode returns to mode 0, where `dout` shows the array byte at `addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| hv_ok | input | 1 | Programming voltage present |
| addr | input | ADDR_W (17) | Byte address |
| din | input | 8 | Write data / command code |
| arr_rdata | input | 8 | Read data from the cell array |
| arr_addr | output | ADDR_W (17) | Address presented to the array |
| dout | output | 8 | Read data to the bus |
| dout_en | output | 1 | Output drive enable |
| out_mode | output | 2 | 0 normal read, 1 verify, 2 identifier |
| busy | output | 1 | Program or erase pulse in progress |
| pgm_req | output | 1 | One-cycle program request |
| erase_req | output | 1 | One-cycle erase request |
| vfy_req | output | 1 | One-cycle verify request |
| op_addr | output | ADDR_W (17) | Latched operation address |
| op_data | output | 8 | Latched program data |

## Verification
The hardest state to reach is the abort path that R6 describes. It requires a null program to be accepted and then, while that program still holds `busy`, a second reset to arrive. The stimulus gets there by writing 0x40 and then 0xFF data, and following immediately with a reset write that ends well inside the PGM_CYCLES window. The bench also varies the bus inside each write: address and data swap values between the falling and rising strobe edges. A design that samples either one at the wrong edge therefore shows up through `op_addr`, `op_data` and the decoded command.

// File: rtl/nvm_cmd_pkg.sv
package nvm_cmd_pkg;

   typedef enum logic [2:0] {
      ST_READ,
      ST_PGM_SETUP,
      ST_ERS_SETUP,
      ST_VERIFY,
      ST_IDENT
   } cmd_state_t;

   localparam logic [1:0] MODE_ARRAY  = 2'd0;
   localparam logic [1:0] MODE_VERIFY = 2'd1;
   localparam logic [1:0] MODE_IDENT  = 2'd2;

   localparam logic [7:0] CODE_PGM_SETUP = 8'h40;
   localparam logic [7:0] CODE_ERASE     = 8'h20;
   localparam logic [7:0] CODE_ERS_VFY   = 8'hA0;
   localparam logic [7:0] CODE_PGM_VFY   = 8'hC0;
   localparam logic [7:0] CODE_IDENT     = 8'h90;
   localparam logic [7:0] CODE_RESET     = 8'hFF;

endpackage

// File: rtl/nvm_we_edge.sv
module nvm_we_edge (
   input  logic clk,
   input  logic rst_n,
   input  logic ce_n,
   input  logic we_n,
   output logic wr_start,
   output logic wr_end
);
   logic wr_act;
   logic wr_act_q;

   assign wr_act = ~ce_n & ~we_n;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) wr_act_q <= 1'b0;
      else        wr_act_q <= wr_act;
   end

   assign wr_start = wr_act & ~wr_act_q;
   assign wr_end   = ~wr_act & wr_act_q;
endmodule

// File: rtl/nvm_pulse_timer.sv
module nvm_pulse_timer #(
   parameter int PGM_CYCLES   = 8,
   parameter int ERASE_CYCLES = 20
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic ld_pgm,
   input  logic ld_erase,
   output logic busy
);
   localparam int MAX_CYC = (PGM_CYCLES > ERASE_CYCLES) ? PGM_CYCLES : ERASE_CYCLES;
   localparam int CNT_W   = $clog2(MAX_CYC + 1);
   localparam logic [CNT_W-1:0] PGM_LOAD = CNT_W'(PGM_CYCLES);
   localparam logic [CNT_W-1:0] ERS_LOAD = CNT_W'(ERASE_CYCLES);

   if (PGM_CYCLES < 1)   $error("PGM_CYCLES must be at least 1");
   if (ERASE_CYCLES < 1) $error("ERASE_CYCLES must be at least 1");

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt <= '0;
      else if (clr)            cnt <= '0;
      else if (ld_pgm)         cnt <= PGM_LOAD;
      else if (ld_erase)       cnt <= ERS_LOAD;
      else if (cnt != '0)      cnt <= cnt - 1'b1;
   end

   assign busy = (cnt != '0);
endmodule

// File: rtl/nvm_cmd_fsm.sv
module nvm_cmd_fsm
   import nvm_cmd_pkg::*;
#(
   parameter int ADDR_W = 17,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hv_ok,
   input  logic              wr_start,
   input  logic              wr_end,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] din,
   input  logic              busy,
   output logic [1:0]        out_mode,
   output logic              pgm_req,
   output logic              erase_req,
   output logic              vfy_req,
   output logic [ADDR_W-1:0] op_addr,
   output logic [DATA_W-1:0] op_data,
   output logic              tmr_clr,
   output logic              tmr_ld_pgm,
   output logic              tmr_ld_erase
);
   cmd_state_t        st, st_nxt;
   logic [ADDR_W-1:0] adr_cap;
   logic              pgm_nxt, ers_nxt, vfy_nxt;
   logic              take_addr, take_data;

   always_comb begin
      st_nxt       = st;
      pgm_nxt      = 1'b0;
      ers_nxt      = 1'b0;
      vfy_nxt      = 1'b0;
      take_addr    = 1'b0;
      take_data    = 1'b0;
      tmr_clr      = 1'b0;
      tmr_ld_pgm   = 1'b0;
      tmr_ld_erase = 1'b0;
      if (!hv_ok) begin
         st_nxt  = ST_READ;
         tmr_clr = 1'b1;
      end else if (wr_end) begin
         if (busy) begin
            if (din == CODE_RESET) begin
               st_nxt  = ST_READ;
               tmr_clr = 1'b1;
            end
         end else begin
            unique case (st)
               ST_PGM_SETUP: begin
                  pgm_nxt    = 1'b1;
                  tmr_ld_pgm = 1'b1;
                  take_addr  = 1'b1;
                  take_data  = 1'b1;
                  st_nxt     = ST_READ;
               end
               ST_ERS_SETUP: begin
                  if (din == CODE_ERASE) begin
                     ers_nxt      = 1'b1;
                     tmr_ld_erase = 1'b1;
                  end
                  st_nxt = ST_READ;
               end
               default: begin
                  unique case (din)
                     CODE_RESET:     st_nxt = ST_READ;
                     CODE_PGM_SETUP: st_nxt = ST_PGM_SETUP;
                     CODE_ERASE:     st_nxt = ST_ERS_SETUP;
                     CODE_IDENT:     st_nxt = ST_IDENT;
                     CODE_ERS_VFY, CODE_PGM_VFY: begin
                        vfy_nxt   = 1'b1;
                        take_addr = 1'b1;
                        st_nxt    = ST_VERIFY;
                     end
                     default:        st_nxt = st;
                  endcase
               end
            endcase
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= ST_READ;
         pgm_req   <= 1'b0;
         erase_req <= 1'b0;
         vfy_req   <= 1'b0;
         adr_cap   <= '0;
         op_addr   <= '0;
         op_data   <= '1;
      end else begin
         st        <= st_nxt;
         pgm_req   <= pgm_nxt;
         erase_req <= ers_nxt;
         vfy_req   <= vfy_nxt;
         if (hv_ok && wr_start && !busy) adr_cap <= addr;
         if (take_addr) op_addr <= adr_cap;
         if (take_data) op_data <= din;
      end
   end

   always_comb begin
      unique case (st)
         ST_VERIFY: out_mode = MODE_VERIFY;
         ST_IDENT:  out_mode = MODE_IDENT;
         default:   out_mode = MODE_ARRAY;
      endcase
   end
endmodule

// File: rtl/nvm_cmd_if.sv
module nvm_cmd_if
   import nvm_cmd_pkg::*;
#(
   parameter int          ADDR_W       = 17,
   parameter int          DATA_W       = 8,
   parameter int          PGM_CYCLES   = 8,
   parameter int          ERASE_CYCLES = 20,
   parameter bit          REG_DOUT     = 1'b0,
   parameter logic [7:0]  MFR_ID       = 8'h5E,
   parameter logic [7:0]  DEV_ID       = 8'hA7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ce_n,
   input  logic              oe_n,
   input  logic              we_n,
   input  logic              hv_ok,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] din,
   input  logic [DATA_W-1:0] arr_rdata,
   output logic [ADDR_W-1:0] arr_addr,
   output logic [DATA_W-1:0] dout,
   output logic              dout_en,
   output logic [1:0]        out_mode,
   output logic              busy,
   output logic              pgm_req,
   output logic              erase_req,
   output logic              vfy_req,
   output logic [ADDR_W-1:0] op_addr,
   output logic [DATA_W-1:0] op_data
);
   if (DATA_W != 8) $error("command codes need DATA_W == 8");
   if (ADDR_W < 1)  $error("ADDR_W must be positive");

   logic wr_start, wr_end;
   logic tmr_clr, tmr_ld_pgm, tmr_ld_erase;
   logic [DATA_W-1:0] dout_c;
   logic              den_c;

   nvm_we_edge u_edge (
      .clk      (clk),
      .rst_n    (rst_n),
      .ce_n     (ce_n),
      .we_n     (we_n),
      .wr_start (wr_start),
      .wr_end   (wr_end)
   );

   nvm_cmd_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
      .clk          (clk),
      .rst_n        (rst_n),
      .hv_ok        (hv_ok),
      .wr_start     (wr_start),
      .wr_end       (wr_end),
      .addr         (addr),
      .din          (din),
      .busy         (busy),
      .out_mode     (out_mode),
      .pgm_req      (pgm_req),
      .erase_req    (erase_req),
      .vfy_req      (vfy_req),
      .op_addr      (op_addr),
      .op_data      (op_data),
      .tmr_clr      (tmr_clr),
      .tmr_ld_pgm   (tmr_ld_pgm),
      .tmr_ld_erase (tmr_ld_erase)
   );

   nvm_pulse_timer #(.PGM_CYCLES(PGM_CYCLES), .ERASE_CYCLES(ERASE_CYCLES)) u_tmr (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (tmr_clr),
      .ld_pgm   (tmr_ld_pgm),
      .ld_erase (tmr_ld_erase),
      .busy     (busy)
   );

   assign arr_addr = (out_mode == MODE_VERIFY) ? op_addr : addr;
   assign den_c    = ~ce_n & ~oe_n & we_n;
   assign dout_c   = (out_mode == MODE_IDENT) ? (addr[0] ? DEV_ID : MFR_ID) : arr_rdata;

   if (REG_DOUT) begin : g_dout_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            dout    <= '1;
            dout_en <= 1'b0;
         end else begin
            dout    <= dout_c;
            dout_en <= den_c;
         end
      end
   end else begin : g_dout_comb
      assign dout    = dout_c;
      assign dout_en = den_c;
   end
endmodule

// File: rtl/nvm_cmd_if_chk.sv
module nvm_cmd_if_chk #(
   parameter int ADDR_W = 17
) (
   input logic       clk,
   input logic       rst_n,
   input logic       hv_ok,
   input logic       busy,
   input logic       pgm_req,
   input logic       erase_req,
   input logic       vfy_req,
   input logic [1:0] out_mode
);
   assert_req_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({pgm_req, erase_req, vfy_req}));

   assert_pgm_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
      pgm_req |=> !pgm_req);

   assert_erase_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
      erase_req |=> !erase_req);

   assert_pgm_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
      pgm_req |-> busy);

   assert_erase_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
      erase_req |-> busy);

   assert_no_req_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> !(pgm_req || erase_req || vfy_req));

   assert_hv_drop_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !hv_ok |=> (!busy && !pgm_req && !erase_req && !vfy_req && out_mode == 2'd0));

   assert_vfy_mode_R8: assert property (@(posedge clk) disable iff (!rst_n)
      vfy_req |-> out_mode == 2'd1);
endmodule

bind nvm_cmd_if nvm_cmd_if_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .hv_ok     (hv_ok),
   .busy      (busy),
   .pgm_req   (pgm_req),
   .erase_req (erase_req),
   .vfy_req   (vfy_req),
   .out_mode  (out_mode)
);

// File: tb/nvm_cmd_if_tb.sv
module nvm_cmd_if_tb;
   localparam int AW  = 17;
   localparam int PGM = 8;
   localparam int ERS = 20;
   localparam logic [7:0] MID = 8'h5E;
   localparam logic [7:0] DID = 8'hA7;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, hv_ok = 1'b1;
   logic [AW-1:0] addr = '0;
   logic [7:0] din = '0;
   logic [7:0] arr_rdata;
   logic [AW-1:0] arr_addr, op_addr;
   logic [7:0] dout, op_data;
   logic dout_en, busy, pgm_req, erase_req, vfy_req;
   logic [1:0] out_mode;

   always #5 clk = ~clk;

   nvm_cmd_if #(.ADDR_W(AW), .PGM_CYCLES(PGM), .ERASE_CYCLES(ERS),
                .MFR_ID(MID), .DEV_ID(DID)) u_dut (
      .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
      .hv_ok(hv_ok), .addr(addr), .din(din), .arr_rdata(arr_rdata),
      .arr_addr(arr_addr), .dout(dout), .dout_en(dout_en), .out_mode(out_mode),
      .busy(busy), .pgm_req(pgm_req), .erase_req(erase_req), .vfy_req(vfy_req),
      .op_addr(op_addr), .op_data(op_data));

   // behavioural cell array: erased bytes read as all ones
   logic [7:0] mem [logic [AW-1:0]];
   int mem_gen = 0;

   function automatic logic [7:0] rd_mem(logic [AW-1:0] a);
      return mem.exists(a) ? mem[a] : 8'hFF;
   endfunction

   always @(posedge clk) begin
      if (pgm_req) begin
         mem[op_addr] = rd_mem(op_addr) & op_data;
         mem_gen = mem_gen + 1;
      end
      if (erase_req) begin
         mem.delete();
         mem_gen = mem_gen + 1;
      end
   end

   always @(arr_addr or mem_gen) arr_rdata = rd_mem(arr_addr);

   int vectors = 0;
   int miscompares = 0;
   bit done = 1'b0;

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      vectors++;
      if (!ok) begin
         miscompares++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   // scoreboard of expected request pulses: kind 0 program, 1 erase, 2 verify
   typedef struct { int kind; logic [AW-1:0] a; logic [7:0] d; string req; } exp_t;
   exp_t expq[$];

   task automatic expect_pulse(input int kind, input logic [AW-1:0] a, input logic [7:0] d, input string req);
      exp_t e;
      e.kind = kind; e.a = a; e.d = d; e.req = req;
      expq.push_back(e);
   endtask

   always @(negedge clk) begin
      if (rst_n && (pgm_req || erase_req || vfy_req)) begin
         int k;
         k = pgm_req ? 0 : (erase_req ? 1 : 2);
         if (expq.size() == 0) begin
            check(1'b0, "R2/R10 unexpected request", 32'(k), 32'hFFFF);
         end else begin
            exp_t e;
            e = expq.pop_front();
            check(k == e.kind, e.req, 32'(k), 32'(e.kind));
            if (k != 1) check(op_addr == e.a, e.req, 32'(op_addr), 32'(e.a));
            if (k == 0) check(op_data == e.d, e.req, 32'(op_data), 32'(e.d));
         end
      end
   end

   // one write: address swaps after the falling edge, data settles before the rising edge
   task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
      ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b1; addr = a; din = ~d;
      @(negedge clk);
      addr = ~a; din = d;
      @(negedge clk);
      we_n = 1'b1;
      @(negedge clk);
      ce_n = 1'b1;
   endtask

   task automatic rd(input logic [AW-1:0] a, output logic [7:0] q);
      ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1; addr = a;
      @(negedge clk);
      q = dout;
      oe_n = 1'b1; ce_n = 1'b1;
   endtask

   task automatic wait_idle();
      while (busy) @(negedge clk);
   endtask

   task automatic finish_run();
      check(expq.size() == 0, "R3 pending expected pulses", 32'(expq.size()), 0);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         check(1'b0, "watchdog", 0, 1);
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

   initial begin
      logic [7:0] q;
      int n;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1
      check(out_mode == 2'd0, "R1 mode", 32'(out_mode), 0);
      check(!busy, "R1 busy", 32'(busy), 0);
      check(!(pgm_req || erase_req || vfy_req), "R1 pulses", 32'({pgm_req, erase_req, vfy_req}), 0);
      // R11
      check(!dout_en, "R11 standby", 32'(dout_en), 0);
      ce_n = 1'b0; oe_n = 1'b0; addr = 17'h5;
      @(negedge clk);
      check(dout_en, "R11 read enable", 32'(dout_en), 1);
      check(dout == 8'hFF, "R11 erased read", 32'(dout), 32'hFF);
      oe_n = 1'b1;
      @(negedge clk);
      check(!dout_en, "R11 output disable", 32'(dout_en), 0);
      ce_n = 1'b1;
      // R2: no programming without voltage
      hv_ok = 1'b0;
      @(negedge clk);
      wr(17'h5, 8'h40);
      wr(17'h5, 8'h00);
      check(!busy, "R2 no busy", 32'(busy), 0);
      hv_ok = 1'b1;
      @(negedge clk);
      rd(17'h5, q);
      check(q == 8'hFF, "R2 array untouched", 32'(q), 32'hFF);
      // R3 / R4 program
      wr(17'h0, 8'h40);
      expect_pulse(0, 17'h123, 8'h5A, "R3 program");
      wr(17'h123, 8'h5A);
      n = 0;
      while (busy) begin n++; @(negedge clk); end
      check(n == PGM, "R4 program busy length", 32'(n), 32'(PGM));
      rd(17'h123, q);
      check(q == 8'h5A, "R3 programmed byte", 32'(q), 32'h5A);
      // R5: commands ignored while busy, reset honoured
      wr(17'h0, 8'h40);
      expect_pulse(0, 17'h200, 8'h0F, "R5 program");
      wr(17'h200, 8'h0F);
      wr(17'h0, 8'h90);
      check(out_mode == 2'd0, "R5 ident ignored while busy", 32'(out_mode), 0);
      check(busy, "R5 still busy", 32'(busy), 1);
      wr(17'h0, 8'hFF);
      check(!busy, "R5 reset clears busy", 32'(busy), 0);
      // R6 null program then abort
      wr(17'h0, 8'h40);
      expect_pulse(0, 17'h300, 8'hFF, "R6 null program");
      wr(17'h300, 8'hFF);
      wr(17'h0, 8'hFF);
      check(!busy, "R6 abort clears busy", 32'(busy), 0);
      check(out_mode == 2'd0, "R6 abort mode", 32'(out_mode), 0);
      rd(17'h300, q);
      check(q == 8'hFF, "R6 byte unchanged", 32'(q), 32'hFF);
      // R7 erase
      wr(17'h0, 8'h20);
      expect_pulse(1, '0, 8'h00, "R7 erase");
      wr(17'h0, 8'h20);
      n = 0;
      while (busy) begin n++; @(negedge clk); end
      check(n == ERS, "R4 erase busy length", 32'(n), 32'(ERS));
      rd(17'h123, q);
      check(q == 8'hFF, "R7 erased byte", 32'(q), 32'hFF);
      wr(17'h0, 8'h20);
      wr(17'h0, 8'h40);
      check(out_mode == 2'd0 && !busy, "R7 erase cancelled", 32'({out_mode, busy}), 0);
      // the write after a cancelled erase is a command, not program data
      wr(17'h44, 8'h00);
      check(!busy, "R7 no program after cancel", 32'(busy), 0);
      // R8 verify
      wr(17'h0, 8'h40);
      expect_pulse(0, 17'h055, 8'h3C, "R8 program");
      wr(17'h055, 8'h3C);
      wait_idle();
      expect_pulse(2, 17'h055, 8'h00, "R8 program verify");
      wr(17'h055, 8'hC0);
      check(out_mode == 2'd1, "R8 verify mode", 32'(out_mode), 1);
      rd(17'h001, q);
      check(q == 8'h3C, "R8 verify reads latched address", 32'(q), 32'h3C);
      expect_pulse(2, 17'h007, 8'h00, "R8 erase verify");
      wr(17'h007, 8'hA0);
      check(arr_addr == 17'h007, "R8 arr_addr latched", 32'(arr_addr), 32'h7);
      // R10 unknown code
      wr(17'h0, 8'h55);
      check(out_mode == 2'd1, "R10 mode kept", 32'(out_mode), 1);
      // R9 identifier
      wr(17'h0, 8'h90);
      check(out_mode == 2'd2, "R9 ident mode", 32'(out_mode), 2);
      rd(17'h0, q);
      check(q == MID, "R9 maker code", 32'(q), 32'(MID));
      rd(17'h1, q);
      check(q == DID, "R9 device code", 32'(q), 32'(DID));
      wr(17'h0, 8'h13);
      check(out_mode == 2'd2, "R10 ident kept", 32'(out_mode), 2);
      // R12 reset to read
      wr(17'h0, 8'hFF);
      check(out_mode == 2'd0, "R12 reset to read", 32'(out_mode), 0);
      rd(17'h055, q);
      check(q == 8'h3C, "R12 array read", 32'(q), 32'h3C);
      // R2 voltage drop cancels set-up, busy and mode
      wr(17'h0, 8'h40);
      hv_ok = 1'b0;
      @(negedge clk);
      hv_ok = 1'b1;
      @(negedge clk);
      wr(17'h10, 8'h00);
      check(!busy, "R2 set-up cancelled", 32'(busy), 0);
      wr(17'h0, 8'h40);
      expect_pulse(0, 17'h11, 8'hF0, "R2 program before drop");
      wr(17'h11, 8'hF0);
      hv_ok = 1'b0;
      @(negedge clk);
      check(!busy, "R2 drop clears busy", 32'(busy), 0);
      hv_ok = 1'b1;
      wr(17'h0, 8'h90);
      hv_ok = 1'b0;
      @(negedge clk);
      check(out_mode == 2'd0, "R2 drop forces read", 32'(out_mode), 0);
      hv_ok = 1'b1;
      repeat (3) @(negedge clk);
      done = 1'b1;
      finish_run();
   end
endmodule